// File: doc/BRIEF.md
# Modem Control, Status and Loopback Unit

This unit sits beside a serial transmitter and receiver and handles the handshake lines of an RS-232 style port. A small control register, written in one cycle, drives four active-low handshake outputs (data-terminal-ready, request-to-send and two general auxiliary outputs). Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through two-flop synchronizers. Their complements appear in a status word together with four sticky change flags. Any set change flag raises an interrupt request when the interrupt enable is high.

A loopback bit in the control register turns the port into a self-test path. The external serial input and all four external handshake inputs are ignored. The transmitter tap is fed straight into the receiver tap, and the serial output pin idles high. All four handshake output pins are parked high, and the status levels follow the control bits instead. Reading the status word with a one-cycle strobe clears the change flags. A change that is detected in the same cycle as the read survives it.

Top module: `modem_link_ctrl`

## Requirements
- R1: Outside loopback each pin is the inverse of its control bit: pin_dtr_n = !ctl_wdata[0], pin_rts_n = !ctl_wdata[1], pin_aux1_n = !ctl_wdata[2], pin_aux2_n = !ctl_wdata[3]. Each pin reflects the value written on the cycle after the ctl_wr edge.
- R2: Outside loopback, the status levels are the complement of the synchronized pins: sts_rdata[4] for pin_cts_n, [5] for pin_dsr_n, [6] for pin_ri_n and [7] for pin_dcd_n. A pin change shows two clock edges after it is applied.
- R3: The change flags sts_rdata[0] (clear-to-send), [1] (data-set-ready) and [3] (carrier detect) set one edge after their status level changes in either direction. They stay set until a status read.
- R4: The ring change flag sts_rdata[2] sets only when the ring status level goes from 0 to 1. A level change from 1 to 0 leaves it clear.
- R5: An edge with sts_rd high clears all four change flags. A flag whose change is detected on that same edge is set afterwards. sts_rdata during the read shows the flags before clearing.
- R6: irq is 1 exactly when irq_en is 1 and at least one change flag is set.
- R7: With the loopback bit ctl_wdata[4] set, pin_sout is 1 and ser_rx equals ser_tx, and pin_sin is ignored. Without it, pin_sout equals ser_tx and ser_rx equals pin_sin.
- R8: In loopback the status levels follow the control bits (clear-to-send from bit 0, data-set-ready from bit 1, ring from bit 2, carrier detect from bit 3). The external handshake inputs then change neither levels nor change flags.
- R9: In loopback all four handshake output pins are 1 whatever the control bits.
- R10: After reset the output pins are 1, the status word is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control bits: [3:0] handshake outputs, [4] loopback |
| sts_rd | input | 1 | Status read strobe, clears change flags |
| sts_rdata | output | 8 | [3:0] change flags, [7:4] status levels |
| irq_en | input | 1 | Handshake-change interrupt enable |
| irq | output | 1 | Handshake-change interrupt request |
| pin_cts_n | input | 1 | Clear-to-send input, active low |
| pin_dsr_n | input | 1 | Data-set-ready input, active low |
| pin_ri_n | input | 1 | Ring indicator input, active low |
| pin_dcd_n | input | 1 | Carrier detect input, active low |
| pin_dtr_n | output | 1 | Data-terminal-ready output, active low |
| pin_rts_n | output | 1 | Request-to-send output, active low |
| pin_aux1_n | output | 1 | Auxiliary output 1, active low |
| pin_aux2_n | output | 1 | Auxiliary output 2, active low |
| ser_tx | input | 1 | Serial bit from the transmitter |
| ser_rx | output | 1 | Serial bit to the receiver |
| pin_sin | input | 1 | External serial input |
| pin_sout | output | 1 | External serial output |

## Verification
A status read and a freshly detected change flag can meet on the same clock edge. The bench provokes this by staggering two input changes by one cycle. The read strobe then lands on the edge that sets the second flag while the first is already pending. The result is judged correct when the earlier flag is gone and the later one is set. A second collision comes from leaving loopback: all four levels jump at once, and the ring flag must follow its rising-only rule together with the other three.

// File: rtl/modem_link_pkg.sv
package modem_link_pkg;
  localparam int unsigned MDM_LINES   = 4;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned IDX_CTS     = 0;
  localparam int unsigned IDX_DSR     = 1;
  localparam int unsigned IDX_RING    = 2;
  localparam int unsigned IDX_DCD     = 3;
  localparam int unsigned CTL_W       = MDM_LINES + 1;
  localparam int unsigned STS_W       = 2 * MDM_LINES;

  typedef logic [MDM_LINES-1:0] mdm_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_route.sv
module mdm_route
  import modem_link_pkg::*;
(
  input  logic     loop_en,
  input  mdm_vec_t ctl_bits,
  input  mdm_vec_t ext_sync_n,
  input  logic     ser_tx,
  input  logic     pin_sin,
  output mdm_vec_t out_pins_n,
  output mdm_vec_t sts_lvl,
  output logic     ser_rx,
  output logic     pin_sout
);
  always_comb begin
    if (loop_en) begin
      out_pins_n = '1;
      sts_lvl    = ctl_bits;
      ser_rx     = ser_tx;
      pin_sout   = 1'b1;
    end else begin
      out_pins_n = ~ctl_bits;
      sts_lvl    = ~ext_sync_n;
      ser_rx     = pin_sin;
      pin_sout   = ser_tx;
    end
  end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import modem_link_pkg::*;
#(
  parameter int unsigned WIDTH    = MDM_LINES,
  parameter int unsigned RING_IDX = IDX_RING
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] delta
);
  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] delta_q, delta_d;
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    if (i == RING_IDX) begin : g_rise
      assign hit[i] = lvl[i] & ~prev_q[i];
    end else begin : g_any
      assign hit[i] = lvl[i] ^ prev_q[i];
    end
  end

  always_comb begin
    prev_d  = lvl;
    delta_d = (delta_q & ~{WIDTH{rd_clr}}) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= prev_d;
      delta_q <= delta_d;
    end
  end

  assign delta = delta_q;

  // R5 / R3: without a read, no set flag may drop
  p_hold_until_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R5: a read with no fresh change leaves every flag clear
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (lvl == prev_q)) |=> (delta_q == '0));

  // R4: ring flag rises only on a 0-to-1 level step
  p_ring_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[RING_IDX]) |-> ($past(lvl[RING_IDX]) && !$past(prev_q[RING_IDX])));
endmodule

// File: rtl/modem_link_ctrl.sv
module modem_link_ctrl
  import modem_link_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sts_rd,
  output logic [STS_W-1:0] sts_rdata,
  input  logic             irq_en,
  output logic             irq,
  input  logic             pin_cts_n,
  input  logic             pin_dsr_n,
  input  logic             pin_ri_n,
  input  logic             pin_dcd_n,
  output logic             pin_dtr_n,
  output logic             pin_rts_n,
  output logic             pin_aux1_n,
  output logic             pin_aux2_n,
  input  logic             ser_tx,
  output logic             ser_rx,
  input  logic             pin_sin,
  output logic             pin_sout
);
  mdm_vec_t ctl_q, ctl_d;
  logic     loop_q, loop_d;
  mdm_vec_t ext_raw_n, ext_sync_n, out_n, lvl, delta;

  always_comb begin
    ctl_d  = ctl_q;
    loop_d = loop_q;
    if (ctl_wr) begin
      ctl_d  = ctl_wdata[MDM_LINES-1:0];
      loop_d = ctl_wdata[MDM_LINES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      loop_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      loop_q <= loop_d;
    end
  end

  always_comb begin
    ext_raw_n[IDX_CTS]  = pin_cts_n;
    ext_raw_n[IDX_DSR]  = pin_dsr_n;
    ext_raw_n[IDX_RING] = pin_ri_n;
    ext_raw_n[IDX_DCD]  = pin_dcd_n;
  end

  mdm_sync #(.WIDTH(MDM_LINES), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_raw_n),
    .dout (ext_sync_n)
  );

  mdm_route u_route (
    .loop_en   (loop_q),
    .ctl_bits  (ctl_q),
    .ext_sync_n(ext_sync_n),
    .ser_tx    (ser_tx),
    .pin_sin   (pin_sin),
    .out_pins_n(out_n),
    .sts_lvl   (lvl),
    .ser_rx    (ser_rx),
    .pin_sout  (pin_sout)
  );

  mdm_delta #(.WIDTH(MDM_LINES), .RING_IDX(IDX_RING)) u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .rd_clr(sts_rd),
    .delta (delta)
  );

  assign pin_dtr_n  = out_n[0];
  assign pin_rts_n  = out_n[1];
  assign pin_aux1_n = out_n[2];
  assign pin_aux2_n = out_n[3];
  assign sts_rdata  = {lvl, delta};
  assign irq        = irq_en & (|delta);

  // R9: handshake pins parked high in loopback
  p_pins_parked_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> ({pin_aux2_n, pin_aux1_n, pin_rts_n, pin_dtr_n} == '1));

  // R7: serial output idles high in loopback
  p_sout_idle_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> (pin_sout && (ser_rx == ser_tx)));

  // R6: a request always has an enabled cause
  p_irq_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (sts_rdata[MDM_LINES-1:0] != '0)));
endmodule

// File: tb/modem_link_ctrl_test.sv
`timescale 1ns/1ps
module modem_link_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [4:0] ctl_wdata;
  logic       sts_rd;
  logic [7:0] sts_rdata;
  logic       irq_en;
  logic       irq;
  logic [3:0] pins_n;
  logic       pin_dtr_n, pin_rts_n, pin_aux1_n, pin_aux2_n;
  logic       ser_tx, ser_rx, pin_sin, pin_sout;
  int         checks = 0;
  int         fails  = 0;

  always #2.5 clk = ~clk;

  modem_link_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_rd(sts_rd), .sts_rdata(sts_rdata), .irq_en(irq_en), .irq(irq),
    .pin_cts_n(pins_n[0]), .pin_dsr_n(pins_n[1]), .pin_ri_n(pins_n[2]),
    .pin_dcd_n(pins_n[3]), .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
    .pin_aux1_n(pin_aux1_n), .pin_aux2_n(pin_aux2_n), .ser_tx(ser_tx),
    .ser_rx(ser_rx), .pin_sin(pin_sin), .pin_sout(pin_sout)
  );

  // {ctl[4:0], pins_n[3:0], expected out pins {aux2,aux1,rts,dtr}, expected levels}
  localparam logic [16:0] VEC [7] = '{
    {5'h00, 4'hF, 4'hF, 4'h0},
    {5'h05, 4'hE, 4'hA, 4'h1},
    {5'h0A, 4'h5, 4'h5, 4'hA},
    {5'h0F, 4'h0, 4'h0, 4'hF},
    {5'h03, 4'h9, 4'hC, 4'h6},
    {5'h15, 4'h0, 4'hF, 4'h5},
    {5'h1A, 4'hF, 4'hF, 4'hA}
  };

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [4:0] v);
    ctl_wdata = v;
    ctl_wr    = 1'b1;
    step(1);
    ctl_wr    = 1'b0;
  endtask

  task automatic read_clr();
    sts_rd = 1'b1;
    step(1);
    sts_rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; sts_rd = 1'b0; irq_en = 1'b1;
    pins_n = 4'hF; ser_tx = 1'b1; pin_sin = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    check("R10 pins", {28'd0, pin_aux2_n, pin_aux1_n, pin_rts_n, pin_dtr_n}, 32'hF);
    check("R10 status", {24'd0, sts_rdata}, 32'h0);
    check("R10 irq", {31'd0, irq}, 32'h0);

    // Table walk: R1, R2, R7, R8, R9
    for (int i = 0; i < 7; i++) begin
      write_ctl(VEC[i][16:12]);
      pins_n = VEC[i][11:8];
      step(4);
      check(VEC[i][16] ? "R9 parked pins" : "R1 pin drive",
            {28'd0, pin_aux2_n, pin_aux1_n, pin_rts_n, pin_dtr_n}, {28'd0, VEC[i][7:4]});
      check(VEC[i][16] ? "R8 loop levels" : "R2 levels",
            {28'd0, sts_rdata[7:4]}, {28'd0, VEC[i][3:0]});
      ser_tx = 1'b0; pin_sin = 1'b1; #0.5;
      check("R7 serial path", {30'd0, pin_sout, ser_rx},
            VEC[i][16] ? 32'h2 : 32'h1);
      read_clr();
    end
    write_ctl(5'h00);
    pins_n = 4'hF;
    step(4);
    read_clr();
    check("R5 cleared", {24'd0, sts_rdata}, 32'h0);

    // R2 latency and R3 flag, R6 enable gating
    irq_en = 1'b0;
    pins_n[0] = 1'b0;
    step(1);
    check("R2 not before sync", {24'd0, sts_rdata}, 32'h00);
    step(1);
    check("R2 level after two edges", {24'd0, sts_rdata}, 32'h10);
    step(1);
    check("R3 cts flag", {24'd0, sts_rdata}, 32'h11);
    check("R6 irq masked", {31'd0, irq}, 32'h0);
    irq_en = 1'b1; #0.5;
    check("R6 irq raised", {31'd0, irq}, 32'h1);

    // R5 read shows then clears
    sts_rd = 1'b1; #0.5;
    check("R5 read value", {24'd0, sts_rdata}, 32'h11);
    step(1);
    sts_rd = 1'b0;
    check("R5 after read", {24'd0, sts_rdata}, 32'h10);
    check("R6 irq dropped", {31'd0, irq}, 32'h0);

    // R5 same-cycle set and clear
    pins_n[0] = 1'b1;
    step(1);
    pins_n[1] = 1'b0;
    step(2);
    check("R5 pre-collision", {24'd0, sts_rdata}, 32'h21);
    read_clr();
    check("R5 collision retains new flag", {24'd0, sts_rdata}, 32'h22);
    read_clr();
    check("R5 collision cleared", {24'd0, sts_rdata}, 32'h20);

    // R4 ring flag edge direction
    pins_n[2] = 1'b0;
    step(3);
    check("R4 ring rise", {24'd0, sts_rdata}, 32'h64);
    read_clr();
    pins_n[2] = 1'b1;
    step(3);
    check("R4 ring fall ignored", {24'd0, sts_rdata}, 32'h20);
    check("R4 no irq on fall", {31'd0, irq}, 32'h0);

    // R3 carrier both directions
    pins_n[3] = 1'b0;
    step(3);
    check("R3 dcd rise", {24'd0, sts_rdata}, 32'hA8);
    read_clr();
    pins_n[3] = 1'b1;
    step(3);
    check("R3 dcd fall", {24'd0, sts_rdata}, 32'h28);
    read_clr();

    // R7 serial in and out of loopback
    ser_tx = 1'b0; pin_sin = 1'b1; #0.5;
    check("R7 normal path", {30'd0, pin_sout, ser_rx}, 32'h1);
    write_ctl(5'h10);
    ser_tx = 1'b1; pin_sin = 1'b0; #0.5;
    check("R7 loop tx to rx", {30'd0, pin_sout, ser_rx}, 32'h3);
    ser_tx = 1'b0; pin_sin = 1'b1; #0.5;
    check("R7 loop ignores sin", {30'd0, pin_sout, ser_rx}, 32'h2);

    // R8 external handshake ignored in loopback
    step(1);
    read_clr();
    check("R8 loop clear", {24'd0, sts_rdata}, 32'h00);
    pins_n = 4'h0;
    step(4);
    check("R8 inputs ignored", {24'd0, sts_rdata}, 32'h00);
    check("R9 pins held", {28'd0, pin_aux2_n, pin_aux1_n, pin_rts_n, pin_dtr_n}, 32'hF);

    // R3 and R4 together when leaving loopback
    write_ctl(5'h00);
    check("R2 levels on exit", {24'd0, sts_rdata}, 32'hF0);
    step(1);
    check("R3 R4 all flags on exit", {24'd0, sts_rdata}, 32'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule